// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

This block is a 32-bit processor core that retires exactly one instruction on every rising clock edge. It supports a nine-instruction subset: word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), an equality branch and an absolute jump. Instruction fetch and data access use two separate internal word arrays, so both can happen in the same cycle. Every instruction is decoded, executed and retired between two consecutive edges.

The core holds the program counter, a 32-entry register file, an opcode decoder, a second-level decoder for the ALU function, a sign extender and the next-PC selection. A testbench fills both arrays through the design hierarchy while reset is held. A debug port shows the current program counter and returns any chosen register combinationally.

Top module: `scyc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 at the next rising edge. While `rst` is high, no register and no data word is written.
- R2: An instruction that is neither a taken branch nor a jump sets the PC to PC+4.
- R3: Opcode 0 is register-to-register, with rs in [25:21], rt in [20:16], rd in [15:11] and the function code in [5:0]. The function codes are 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or and 0x2A signed set-less-than, which writes 1 or 0. The result goes to rd.
- R4: Opcode 35 loads into rt the data word at byte address rs + sign-extended [15:0]. Word index = address bits [7:2] at the default depth of 64 words.
- R5: Opcode 43 stores rt to the data word at rs + sign-extended [15:0], using the same indexing, and writes no register.
- R6: Opcode 4 compares rs and rt by subtraction. When they are equal, the PC becomes PC+4 plus the sign-extended [15:0] shifted left by 2, forward or backward. Otherwise it becomes PC+4.
- R7: Opcode 2 sets the PC to {(PC+4)[31:28], [25:0], 2'b00}.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any other opcode, or an opcode-0 function code outside the five listed, acts as a no-op. It writes no register and no data word, and the PC advances by 4.
- R10: Register reads are combinational, so an instruction whose destination is also a source computes with the value held before its own write.
- R11: `dbg_pc` shows the current PC, and `dbg_data` returns the register selected by `dbg_sel` with no delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_sel` (0 for register 0) |
| dbg_pc | output | 32 | Current program counter |

## Verification
Each instruction's effects are due at the first rising edge after it is fetched. A register write, a data-word write and the next PC all become visible one edge later. The bench releases reset on a falling edge, so after N further rising edges exactly N instructions have retired. Every check is taken on a falling edge after a counted number of rising edges. Register values are read through the combinational debug port, one time unit after the selector changes. Stores are checked by loading the word back into a register on a later cycle.

// File: rtl/scyc_pkg.sv
package scyc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    localparam logic [5:0] OP_REG   = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_fn_e;

    typedef enum logic [1:0] {
        CLS_ADDR,
        CLS_CMP,
        CLS_FUNCT,
        CLS_NONE
    } alu_cls_e;

    typedef struct packed {
        logic     reg_wr;
        logic     mem_wr;
        logic     load_sel;
        logic     imm_b;
        logic     dst_rd;
        logic     is_beq;
        logic     is_jump;
        alu_cls_e cls;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]     opc;
        logic [RAW-1:0] rs;
        logic [RAW-1:0] rt;
        logic [15:0]    imm;
    } ifields_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic known_opc(input logic [5:0] o);
        return (o == OP_REG) || (o == OP_JUMP) || (o == OP_BEQ) ||
               (o == OP_LOAD) || (o == OP_STORE);
    endfunction

endpackage

// File: rtl/scyc_main_dec.sv
module scyc_main_dec
    import scyc_pkg::*;
(
    input  logic [5:0] opc,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{reg_wr: 1'b0, mem_wr: 1'b0, load_sel: 1'b0, imm_b: 1'b0,
                 dst_rd: 1'b0, is_beq: 1'b0, is_jump: 1'b0, cls: CLS_NONE};
        unique case (opc)
            OP_REG: begin
                ctrl.reg_wr = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OP_LOAD: begin
                ctrl.reg_wr   = 1'b1;
                ctrl.load_sel = 1'b1;
                ctrl.imm_b    = 1'b1;
                ctrl.cls      = CLS_ADDR;
            end
            OP_STORE: begin
                ctrl.mem_wr = 1'b1;
                ctrl.imm_b  = 1'b1;
                ctrl.cls    = CLS_ADDR;
            end
            OP_BEQ: begin
                ctrl.is_beq = 1'b1;
                ctrl.cls    = CLS_CMP;
            end
            OP_JUMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/scyc_alu_ctl.sv
module scyc_alu_ctl
    import scyc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_fn_e    fn,
    output logic       fn_ok
);
    always_comb begin
        fn    = ALU_ADD;
        fn_ok = 1'b1;
        unique case (cls)
            CLS_ADDR: fn = ALU_ADD;
            CLS_CMP:  fn = ALU_SUB;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn_ok = 1'b0;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/scyc_alu.sv
module scyc_alu
    import scyc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);
    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/scyc_regfile.sv
module scyc_regfile
    import scyc_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_d,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_d,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [1:N-1];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    assign rd_d = (ra_d == '0) ? '0 : regs[ra_d];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0 && ra_d == wa) |=> (($past(ra_d) != ra_d) || rd_d == $past(wd))); // R3
endmodule

// File: rtl/scyc_core.sv
module scyc_core
    import scyc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  dbg_sel,
    output logic [XLEN-1:0] dbg_data,
    output logic [XLEN-1:0] dbg_pc
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
        for (int i = 0; i < DMEM_WORDS; i++) dmem[i] = '0;
    end

    logic [XLEN-1:0] pc, pc_seq, pc_next, br_tgt, j_tgt;
    logic [XLEN-1:0] instr, imm_x, src_a, src_b, alu_b, alu_y, ld_data, wb_data;
    logic [RAW-1:0]  rd_f, dst;
    logic [5:0]      funct;
    ifields_t        f;
    ctrl_t           ctrl;
    alu_fn_e         fn;
    logic            fn_ok, alu_zero, take_br, rf_we, dm_we;

    assign instr = imem[pc[IAW+1:2]];
    assign f     = '{opc: instr[31:26], rs: instr[25:21], rt: instr[20:16], imm: instr[15:0]};
    assign rd_f  = instr[15:11];
    assign funct = instr[5:0];
    assign imm_x = sext16(f.imm);

    scyc_main_dec u_dec (.opc(f.opc), .ctrl(ctrl));

    scyc_alu_ctl u_actl (.cls(ctrl.cls), .funct(funct), .fn(fn), .fn_ok(fn_ok));

    scyc_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra_a(f.rs),
        .ra_b(f.rt),
        .ra_d(dbg_sel),
        .rd_a(src_a),
        .rd_b(src_b),
        .rd_d(dbg_data),
        .we  (rf_we),
        .wa  (dst),
        .wd  (wb_data)
    );

    assign alu_b = ctrl.imm_b ? imm_x : src_b;

    scyc_alu #(.W(XLEN)) u_alu (.fn(fn), .a(src_a), .b(alu_b), .y(alu_y), .zero(alu_zero));

    assign ld_data = dmem[alu_y[DAW+1:2]];
    assign wb_data = ctrl.load_sel ? ld_data : alu_y;
    assign dst     = ctrl.dst_rd ? rd_f : f.rt;
    assign rf_we   = ctrl.reg_wr && fn_ok && !rst;
    assign dm_we   = ctrl.mem_wr && !rst;

    always_ff @(posedge clk) begin
        if (dm_we) dmem[alu_y[DAW+1:2]] <= src_b;
    end

    assign pc_seq  = pc + 32'd4;
    assign br_tgt  = pc_seq + {imm_x[XLEN-3:0], 2'b00};
    assign j_tgt   = {pc_seq[31:28], instr[25:0], 2'b00};
    assign take_br = ctrl.is_beq && alu_zero;

    always_comb begin
        if (ctrl.is_jump)  pc_next = j_tgt;
        else if (take_br)  pc_next = br_tgt;
        else               pc_next = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign dbg_pc = pc;

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0)); // R1

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (!take_br && !ctrl.is_jump) |=> (pc == $past(pc) + 32'd4)); // R2

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        (ctrl.is_beq && src_a == src_b) |=> (pc == $past(pc) + 32'd4 + ($past(imm_x) << 2))); // R6

    AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00})); // R7

    AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (rst)
        (f.opc == OP_STORE) |-> (dm_we && !rf_we)); // R5

    AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
        (!known_opc(f.opc) || (f.opc == OP_REG && funct != FN_ADD && funct != FN_SUB &&
         funct != FN_AND && funct != FN_OR && funct != FN_SLT)) |-> (!rf_we && !dm_we)); // R9
endmodule

// File: tb/tb_scyc_core.sv
`timescale 1ns/1ps
module tb_scyc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_data, dbg_pc;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    scyc_core dut (.clk(clk), .rst(rst), .dbg_sel(dbg_sel), .dbg_data(dbg_data), .dbg_pc(dbg_pc));

    function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] a);
        return {6'd2, a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask
    task automatic chk_reg(input string tag, input int idx, input logic [31:0] exp);
        dbg_sel = 5'(idx);
        #1;
        chk(tag, dbg_data, exp);
    endtask
    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask
    task automatic clear_imem;
        for (int i = 0; i < 64; i++) dut.imem[i] = 32'd0;
    endtask
    task automatic do_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc after reset", dbg_pc, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_alu_load;
        clear_imem();
        dut.imem[0] = enc_i(6'd35, 0, 1, 16'd0);
        dut.imem[1] = enc_i(6'd35, 0, 2, 16'd4);
        dut.imem[2] = enc_r(1, 2, 3, 6'h20);
        dut.imem[3] = enc_r(1, 2, 4, 6'h22);
        dut.imem[4] = enc_r(1, 2, 5, 6'h24);
        dut.imem[5] = enc_r(1, 2, 6, 6'h25);
        dut.imem[6] = enc_i(6'd35, 0, 7, 16'd8);
        dut.imem[7] = enc_r(7, 1, 8, 6'h2A);
        dut.imem[8] = enc_r(1, 7, 9, 6'h2A);
        dut.imem[9] = enc_r(1, 1, 1, 6'h20);
        do_reset();
        run(2);
        chk("R2 pc after two loads", dbg_pc, 32'd8);
        chk_reg("R4 load word 0", 1, 32'd7);
        run(8);
        chk("R2 R11 pc after ten", dbg_pc, 32'd40);
        chk_reg("R10 self add", 1, 32'd14);
        chk_reg("R4 load word 1", 2, 32'd5);
        chk_reg("R3 add", 3, 32'd12);
        chk_reg("R3 sub", 4, 32'd2);
        chk_reg("R3 and", 5, 32'd5);
        chk_reg("R3 or", 6, 32'd7);
        chk_reg("R4 negative word", 7, 32'hFFFF_FFFD);
        chk_reg("R3 slt signed true", 8, 32'd1);
        chk_reg("R3 slt false", 9, 32'd0);
    endtask

    task automatic t_reset_hold;
        clear_imem();
        dut.imem[0] = enc_i(6'd35, 0, 9, 16'd0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reg("R1 no write in reset", 9, 32'd0);
        chk("R1 pc held", dbg_pc, 32'd0);
        rst = 1'b0;
        run(1);
        chk_reg("R1 runs after release", 9, 32'd7);
        run(3);
        rst = 1'b1;
        run(1);
        chk("R1 mid-run reset", dbg_pc, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_store;
        clear_imem();
        dut.imem[0] = enc_i(6'd35, 0, 1, 16'd12);
        dut.imem[1] = enc_i(6'd43, 0, 1, 16'd20);
        dut.imem[2] = enc_i(6'd35, 0, 2, 16'd20);
        dut.imem[3] = enc_i(6'd35, 0, 4, 16'd28);
        dut.imem[4] = enc_i(6'd35, 4, 5, 16'hFFF4);
        do_reset();
        run(5);
        chk_reg("R5 store reads back", 2, 32'h1234_5678);
        chk_reg("R5 store leaves rt", 1, 32'h1234_5678);
        chk_reg("R4 negative offset", 5, 32'h1234_5678);
    endtask

    task automatic t_branch;
        clear_imem();
        dut.imem[0] = enc_i(6'd35, 0, 1, 16'd0);
        dut.imem[1] = enc_i(6'd35, 0, 2, 16'd0);
        dut.imem[2] = enc_i(6'd4, 1, 2, 16'd2);
        dut.imem[5] = enc_i(6'd4, 1, 0, 16'd5);
        dut.imem[6] = enc_i(6'd35, 0, 4, 16'd4);
        dut.imem[7] = enc_i(6'd4, 0, 0, 16'hFFFE);
        do_reset();
        run(3);
        chk("R6 taken forward", dbg_pc, 32'd20);
        run(1);
        chk("R6 not taken", dbg_pc, 32'd24);
        run(1);
        chk_reg("R6 fall-through executes", 4, 32'd5);
        run(1);
        chk("R6 taken backward", dbg_pc, 32'd24);
    endtask

    task automatic t_jump;
        clear_imem();
        dut.imem[0] = enc_j(26'd5);
        dut.imem[5] = enc_j(26'h3FF_FFFF);
        do_reset();
        run(1);
        chk("R7 jump low", dbg_pc, 32'd20);
        run(1);
        chk("R7 jump full field", dbg_pc, 32'h0FFF_FFFC);
        run(1);
        chk("R2 R9 nop word advances", dbg_pc, 32'h1000_0000);
        run(1);
        chk("R7 keeps upper pc bits", dbg_pc, 32'h1000_0014);
    endtask

    task automatic t_zero_unknown;
        clear_imem();
        dut.imem[0] = enc_i(6'd35, 0, 1, 16'd0);
        dut.imem[1] = enc_r(1, 1, 0, 6'h20);
        dut.imem[2] = enc_r(0, 1, 2, 6'h20);
        dut.imem[3] = enc_i(6'h3F, 0, 1, 16'hFFFF);
        dut.imem[4] = enc_r(1, 1, 1, 6'h27);
        dut.imem[5] = enc_i(6'h08, 0, 1, 16'd5);
        dut.imem[6] = enc_i(6'h28, 0, 0, 16'd0);
        dut.imem[7] = enc_i(6'd35, 0, 3, 16'd0);
        do_reset();
        run(3);
        chk_reg("R8 r0 reads zero", 0, 32'd0);
        chk_reg("R8 r0 as source", 2, 32'd7);
        run(5);
        chk_reg("R9 no reg write", 1, 32'd7);
        chk_reg("R9 no mem write", 3, 32'd7);
        chk("R9 pc advance", dbg_pc, 32'd32);
    endtask

    initial begin
        #1;
        dut.dmem[0] = 32'd7;
        dut.dmem[1] = 32'd5;
        dut.dmem[2] = 32'hFFFF_FFFD;
        dut.dmem[3] = 32'h1234_5678;
        dut.dmem[7] = 32'd24;
        t_alu_load();
        t_reset_hold();
        t_store();
        t_branch();
        t_jump();
        t_zero_unknown();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule